// File: doc/BRIEF.md
# Four-level eight-source interrupt controller

This block arbitrates interrupt requests for an 8-bit microcontroller core. It holds three configuration registers and one extra external-interrupt control register on a small special-function-register bus. From these it builds a two-bit priority for each of eight sources. Four of the sources are external pins, which can be sampled as falling-edge or low-level triggers. The other four are pending lines from three timers and a serial port.

Each cycle the controller picks the best enabled request. It offers that request to the core as a source index and a level. The request is offered only if its level is strictly above every service routine that is still running. A nesting tracker holds one bit per level. It pushes the level of each request the core accepts, and it pops the top level when the core signals a return from interrupt. The core fetches the vector address itself from the source index.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq_req` is low and `isr_lvls` is 0.
- R2: Register reads are combinational from `sfr_addr`, and a write with `sfr_wr` takes effect at the next clock edge. At A8H, bit 6 always reads 0. At B8H, bits 7:6 always read 0. B7H reads back all 8 bits. C0H reads back its written control bits, and bit 1 and bit 5 show the live flags of external 2 and external 3. Any other address reads 0.
- R3: A source is requested only when A8H bit 7 (global enable) is set and the source's own enable bit is set. Source index i in 0..5 uses A8H bit i. External 2 uses C0H bit 2, and external 3 uses C0H bit 6.
- R4: The level of a source is {high bit, low bit}, and a higher level wins. For index i in 0..5, the low bit is B8H bit i and the high bit is B7H bit i. For external 2, the low bit is C0H bit 3 and the high bit is B7H bit 6. For external 3, the low bit is C0H bit 7 and the high bit is B7H bit 7.
- R5: Sources at the same level are ordered by index, and the lowest index wins. The indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 external 2, 7 external 3. `irq_vec` carries the index and `irq_lvl` carries the level.
- R6: In edge mode, a pin flag sets when one sample reads high and the next sample reads low. `ext01_edge` bits 0 and 1 select edge mode for external 0 and 1. C0H bit 0 selects edge mode for external 2, and C0H bit 4 selects it for external 3.
- R7: Accepting an edge-mode external source clears its flag. In low-level mode, the request equals the latest sample being low, and accepting it has no effect on it. The timer and serial inputs are level requests that the controller never clears.
- R8: The pins are sampled only in cycles where `cyc_en` is high. Pin activity while `cyc_en` is low is ignored.
- R9: A request is offered only when its level is strictly higher than every level set in `isr_lvls`. When `irq_ack` is high while a request is offered, the offered level's bit in `isr_lvls` is set.
- R10: A `reti` pulse clears the highest set bit of `isr_lvls`, and it has no effect when `isr_lvls` is empty. When `reti` and an accepted `irq_ack` arrive in the same cycle, the pop is applied first and then the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe for pin sampling |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| ext_n | input | 4 | External interrupt pins 0..3, active low |
| ext01_edge | input | 2 | Edge-mode select for external 0 and 1 |
| tmr_req | input | 3 | Timer 0, 1, 2 pending lines |
| ser_req | input | 1 | Serial port pending line |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 3 | Index of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| irq_ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Return-from-interrupt pulse |
| isr_lvls | output | 4 | In-service level mask |

## Verification
The hardest situation to reach is a three-deep interplay of nesting. Two of its cases are a pending request that sits at the same level as a running routine, and a request that must come back the moment that routine returns. The stimulus accepts a level-1 external edge first. It then raises a timer first at level 0 and then at level 2. It accepts the timer and checks that the timer's own still-pending line is held off. It then returns once and checks that the request reappears. A final case drives `irq_ack` and `reti` in the same cycle while level 2 is in service, so that the ordering of pop before push can be observed in `isr_lvls`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 8;
  localparam int NLVL = 4;
  localparam int NEXT = 4;
  localparam int LVLW = $clog2(NLVL);
  localparam int IDXW = $clog2(NSRC);
  localparam logic [7:0] ADDR_EN   = 8'hA8;
  localparam logic [7:0] ADDR_PLO  = 8'hB8;
  localparam logic [7:0] ADDR_PHI  = 8'hB7;
  localparam logic [7:0] ADDR_XCTL = 8'hC0;
endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_en,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] sw_we,
  input  logic [N-1:0] sw_val,
  input  logic [N-1:0] svc_clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic smp_q, smp_d, flg_q, flg_d;

    always_comb begin
      smp_d = smp_q;
      flg_d = flg_q;
      if (sw_we[g]) flg_d = sw_val[g];
      if (svc_clr[g] && edge_mode[g]) flg_d = 1'b0;
      if (cyc_en) begin
        smp_d = pin_n[g];
        if (edge_mode[g]) begin
          if (smp_q && !pin_n[g]) flg_d = 1'b1;
        end else begin
          flg_d = ~pin_n[g];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b1;
        flg_q <= 1'b0;
      end else begin
        smp_q <= smp_d;
        flg_q <= flg_d;
      end
    end

    assign flag[g] = flg_q;
  end
endmodule

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
  import irq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                addr,
  input  logic                      wr,
  input  logic [7:0]                wdata,
  input  logic [NEXT-1:0]           ext_flag,
  output logic [7:0]                rdata,
  output logic                      glb_en,
  output logic [NSRC-1:0]           src_en,
  output logic [NSRC-1:0][LVLW-1:0] src_lvl,
  output logic [1:0]                xedge,
  output logic [1:0]                xflag_we,
  output logic [1:0]                xflag_val
);
  logic [7:0] ie_q, ie_d, iph_q, iph_d, xc_q, xc_d;
  logic [5:0] ip_q, ip_d;
  logic       we_ie, we_ip, we_iph, we_xc;

  assign we_ie  = wr && (addr == ADDR_EN);
  assign we_ip  = wr && (addr == ADDR_PLO);
  assign we_iph = wr && (addr == ADDR_PHI);
  assign we_xc  = wr && (addr == ADDR_XCTL);

  always_comb begin
    ie_d  = we_ie  ? (wdata & 8'hBF) : ie_q;
    ip_d  = we_ip  ? wdata[5:0]      : ip_q;
    iph_d = we_iph ? wdata           : iph_q;
    xc_d  = we_xc  ? (wdata & 8'hDD) : xc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      ip_q  <= '0;
      iph_q <= '0;
      xc_q  <= '0;
    end else begin
      ie_q  <= ie_d;
      ip_q  <= ip_d;
      iph_q <= iph_d;
      xc_q  <= xc_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_EN:   rdata = ie_q;
      ADDR_PLO:  rdata = {2'b00, ip_q};
      ADDR_PHI:  rdata = iph_q;
      ADDR_XCTL: rdata = xc_q | {2'b00, ext_flag[3], 3'b000, ext_flag[2], 1'b0};
      default:   rdata = 8'h00;
    endcase
  end

  assign glb_en = ie_q[7];
  assign src_en = {xc_q[6], xc_q[2], ie_q[5:0]};

  for (genvar i = 0; i < 6; i++) begin : g_std_lvl
    assign src_lvl[i] = {iph_q[i], ip_q[i]};
  end
  assign src_lvl[6] = {iph_q[6], xc_q[3]};
  assign src_lvl[7] = {iph_q[7], xc_q[7]};

  assign xedge     = {xc_q[4], xc_q[0]};
  assign xflag_we  = {2{we_xc}};
  assign xflag_val = {wdata[5], wdata[1]};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           pend,
  input  logic [NSRC-1:0]           en,
  input  logic                      glb_en,
  input  logic [NSRC-1:0][LVLW-1:0] lvl,
  input  logic                      ack,
  input  logic                      reti,
  output logic                      req,
  output logic [IDXW-1:0]           vec,
  output logic [LVLW-1:0]           req_lvl,
  output logic [NLVL-1:0]           isr,
  output logic [NSRC-1:0]           take
);
  logic [NSRC-1:0] eff;
  logic            found, busy, accept;
  logic [LVLW-1:0] best_lvl, cur_lvl;
  logic [IDXW-1:0] best_idx;
  logic [NLVL-1:0] isr_q, isr_d, top_oh;

  assign eff = pend & en & {NSRC{glb_en}};

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i] && (!found || lvl[i] >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl[i];
        best_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    cur_lvl = '0;
    for (int j = 0; j < NLVL; j++) begin
      if (isr_q[j]) cur_lvl = LVLW'(j);
    end
  end

  assign busy   = |isr_q;
  assign top_oh = busy ? (NLVL'(1) << cur_lvl) : '0;
  assign req    = found && (!busy || best_lvl > cur_lvl);
  assign accept = ack && req;

  always_comb begin
    isr_d = isr_q;
    if (reti)   isr_d = isr_d & ~top_oh;
    if (accept) isr_d = isr_d | (NLVL'(1) << best_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign take    = accept ? (NSRC'(1) << best_idx) : '0;
  assign vec     = best_idx;
  assign req_lvl = best_lvl;
  assign isr     = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic [7:0]      sfr_wdata,
  output logic [7:0]      sfr_rdata,
  input  logic [NEXT-1:0] ext_n,
  input  logic [1:0]      ext01_edge,
  input  logic [2:0]      tmr_req,
  input  logic            ser_req,
  output logic            irq_req,
  output logic [IDXW-1:0] irq_vec,
  output logic [LVLW-1:0] irq_lvl,
  input  logic            irq_ack,
  input  logic            reti,
  output logic [NLVL-1:0] isr_lvls
);
  logic [1:0]                rst_pipe;
  logic                      rst_ni;
  logic [NEXT-1:0]           ext_flag;
  logic                      glb_en;
  logic [NSRC-1:0]           src_en, pend, take;
  logic [NSRC-1:0][LVLW-1:0] src_lvl;
  logic [1:0]                xedge, xflag_we, xflag_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  irq_sfr_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(sfr_addr), .wr(sfr_wr), .wdata(sfr_wdata),
    .ext_flag(ext_flag), .rdata(sfr_rdata), .glb_en(glb_en), .src_en(src_en),
    .src_lvl(src_lvl), .xedge(xedge), .xflag_we(xflag_we), .xflag_val(xflag_val)
  );

  irq_ext_detect #(.N(NEXT)) u_ext (
    .clk(clk), .rst_n(rst_ni), .cyc_en(cyc_en), .pin_n(ext_n),
    .edge_mode({xedge, ext01_edge}),
    .sw_we({xflag_we, 2'b00}), .sw_val({xflag_val, 2'b00}),
    .svc_clr({take[7], take[6], take[2], take[0]}),
    .flag(ext_flag)
  );

  assign pend = {ext_flag[3], ext_flag[2], tmr_req[2], ser_req,
                 tmr_req[1], ext_flag[1], tmr_req[0], ext_flag[0]};

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_ni), .pend(pend), .en(src_en), .glb_en(glb_en),
    .lvl(src_lvl), .ack(irq_ack), .reti(reti), .req(irq_req), .vec(irq_vec),
    .req_lvl(irq_lvl), .isr(isr_lvls), .take(take)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst_ni,
  input logic            glb_en,
  input logic [NSRC-1:0] src_en,
  input logic            irq_req,
  input logic [IDXW-1:0] irq_vec,
  input logic [LVLW-1:0] irq_lvl,
  input logic            irq_ack,
  input logic            reti,
  input logic [NLVL-1:0] isr_lvls
);
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_req |-> (glb_en && src_en[irq_vec]));

  p_strict_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_req |-> ((isr_lvls >> irq_lvl) == '0));

  p_push_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack && irq_req) |=> isr_lvls[$past(irq_lvl)]);

  p_pop_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (reti && !irq_ack && isr_lvls != '0) |=>
      ($countones(isr_lvls) == $countones($past(isr_lvls)) - 1));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!irq_ack && !reti) |=> $stable(isr_lvls));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .glb_en(glb_en), .src_en(src_en),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .irq_ack(irq_ack), .reti(reti), .isr_lvls(isr_lvls)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, cyc_en, sfr_wr, ser_req, irq_ack, reti, irq_req;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic [3:0] ext_n, isr_lvls;
  logic [1:0] ext01_edge, irq_lvl;
  logic [2:0] tmr_req, irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      rid;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext_n(ext_n), .ext01_edge(ext01_edge), .tmr_req(tmr_req),
    .ser_req(ser_req), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .irq_ack(irq_ack), .reti(reti), .isr_lvls(isr_lvls)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = sfr_rdata;
        1: act = {7'd0, irq_req};
        2: act = {5'd0, irq_vec};
        3: act = {6'd0, irq_lvl};
        default: act = {4'd0, isr_lvls};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d actual %h expected %h", it.rid, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(string rid, int kind, logic [7:0] exp);
    item_t it;
    it.rid = rid; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    tick();
    sfr_wr = 1'b0;
  endtask

  task automatic rd_chk(string rid, logic [7:0] a, logic [7:0] exp);
    sfr_addr = a;
    expect_item(rid, 0, exp);
    settle();
  endtask

  task automatic out_chk(string rid, logic r, logic [2:0] v, logic [1:0] l, logic [3:0] s);
    expect_item(rid, 1, {7'd0, r});
    if (r) begin
      expect_item(rid, 2, {5'd0, v});
      expect_item(rid, 3, {6'd0, l});
    end
    expect_item(rid, 4, {4'd0, s});
    settle();
  endtask

  task automatic ack_pulse(logic with_reti);
    irq_ack = 1'b1; reti = with_reti;
    tick();
    irq_ack = 1'b0; reti = 1'b0;
  endtask

  task automatic reti_pulse();
    reti = 1'b1;
    tick();
    reti = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cyc_en = 1'b1; sfr_wr = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    ext_n = 4'hF; ext01_edge = 2'b00; tmr_req = 3'b000; ser_req = 1'b0;
    irq_ack = 1'b0; reti = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd_chk("R1", 8'hA8, 8'h00);
    rd_chk("R1", 8'hB8, 8'h00);
    rd_chk("R1", 8'hB7, 8'h00);
    rd_chk("R1", 8'hC0, 8'h00);
    out_chk("R1", 1'b0, 3'd0, 2'd0, 4'h0);

    // R2 readback masks
    wr(8'hA8, 8'hFF); rd_chk("R2", 8'hA8, 8'hBF);
    wr(8'hB8, 8'hFF); rd_chk("R2", 8'hB8, 8'h3F);
    wr(8'hB7, 8'hA5); rd_chk("R2", 8'hB7, 8'hA5);
    wr(8'hC0, 8'h55); rd_chk("R2", 8'hC0, 8'h55);
    rd_chk("R2", 8'h90, 8'h00);
    wr(8'hA8, 8'h00); wr(8'hB8, 8'h00); wr(8'hB7, 8'h00); wr(8'hC0, 8'h00);

    // R3 global and own enable
    tmr_req[0] = 1'b1;
    wr(8'hA8, 8'h02); out_chk("R3", 1'b0, 3'd0, 2'd0, 4'h0);
    wr(8'hA8, 8'h80); out_chk("R3", 1'b0, 3'd0, 2'd0, 4'h0);
    wr(8'hA8, 8'h82); out_chk("R3", 1'b1, 3'd1, 2'd0, 4'h0);

    // R5 polling order at equal level
    ser_req = 1'b1;
    wr(8'hA8, 8'h92); out_chk("R5", 1'b1, 3'd1, 2'd0, 4'h0);
    tmr_req[0] = 1'b0; #1; out_chk("R5", 1'b1, 3'd4, 2'd0, 4'h0);

    // R4 level formation
    tmr_req[0] = 1'b1;
    wr(8'hB8, 8'h10); out_chk("R4", 1'b1, 3'd4, 2'd1, 4'h0);
    wr(8'hB7, 8'h02); out_chk("R4", 1'b1, 3'd1, 2'd2, 4'h0);
    wr(8'hB8, 8'h00); wr(8'hB7, 8'h00);
    tmr_req[0] = 1'b0; ser_req = 1'b0;

    // R6 edge on external 2, level 1
    wr(8'hC0, 8'h0D); wr(8'hA8, 8'h80);
    out_chk("R6", 1'b0, 3'd0, 2'd0, 4'h0);
    ext_n[2] = 1'b0; tick();
    out_chk("R6", 1'b1, 3'd6, 2'd1, 4'h0);
    rd_chk("R6", 8'hC0, 8'h0F);
    ext_n[2] = 1'b1; tick();
    out_chk("R6", 1'b1, 3'd6, 2'd1, 4'h0);

    // R7 and R9 accept clears edge flag, pushes level 1
    ack_pulse(1'b0);
    out_chk("R7", 1'b0, 3'd0, 2'd0, 4'h2);
    rd_chk("R7", 8'hC0, 8'h0D);

    // R9 strict preemption
    wr(8'hA8, 8'h88); tmr_req[1] = 1'b1; #1;
    out_chk("R9", 1'b0, 3'd0, 2'd0, 4'h2);
    wr(8'hB7, 8'h08); out_chk("R9", 1'b1, 3'd3, 2'd2, 4'h2);
    ack_pulse(1'b0);
    out_chk("R9", 1'b0, 3'd0, 2'd0, 4'h6);

    // R10 return pops top, timer line remains pending (R7)
    reti_pulse();
    out_chk("R10", 1'b1, 3'd3, 2'd2, 4'h2);
    tmr_req[1] = 1'b0; #1;
    out_chk("R10", 1'b0, 3'd0, 2'd0, 4'h2);
    reti_pulse(); out_chk("R10", 1'b0, 3'd0, 2'd0, 4'h0);
    reti_pulse(); out_chk("R10", 1'b0, 3'd0, 2'd0, 4'h0);
    wr(8'hB7, 8'h00);

    // R7 low-level mode on external 0
    wr(8'hC0, 8'h00); wr(8'hA8, 8'h81);
    ext_n[0] = 1'b0; tick();
    out_chk("R7", 1'b1, 3'd0, 2'd0, 4'h0);
    ack_pulse(1'b0);
    out_chk("R7", 1'b0, 3'd0, 2'd0, 4'h1);
    reti_pulse();
    out_chk("R7", 1'b1, 3'd0, 2'd0, 4'h0);
    ext_n[0] = 1'b1; tick();
    out_chk("R7", 1'b0, 3'd0, 2'd0, 4'h0);

    // R8 no sampling without cyc_en, external 1 in edge mode
    ext01_edge = 2'b10; wr(8'hA8, 8'h84);
    cyc_en = 1'b0; ext_n[1] = 1'b0; tick(); tick();
    ext_n[1] = 1'b1; tick();
    out_chk("R8", 1'b0, 3'd0, 2'd0, 4'h0);
    cyc_en = 1'b1; tick();
    ext_n[1] = 1'b0; tick();
    out_chk("R8", 1'b1, 3'd2, 2'd0, 4'h0);
    ext_n[1] = 1'b1;
    ack_pulse(1'b0);
    out_chk("R7", 1'b0, 3'd0, 2'd0, 4'h1);
    reti_pulse();
    out_chk("R7", 1'b0, 3'd0, 2'd0, 4'h0);

    // R6 and R4 external 3 with high bit from B7H bit 7
    ext01_edge = 2'b00;
    wr(8'hA8, 8'h80); wr(8'hC0, 8'h50); wr(8'hB7, 8'h80);
    ext_n[3] = 1'b0; tick();
    out_chk("R6", 1'b1, 3'd7, 2'd2, 4'h0);
    rd_chk("R6", 8'hC0, 8'h70);
    ext_n[3] = 1'b1;
    ack_pulse(1'b0);
    out_chk("R9", 1'b0, 3'd0, 2'd0, 4'h4);

    // R10 pop then push in one cycle
    wr(8'hB8, 8'h02); wr(8'hB7, 8'h82); wr(8'hA8, 8'h82);
    tmr_req[0] = 1'b1; #1;
    out_chk("R4", 1'b1, 3'd1, 2'd3, 4'h4);
    ack_pulse(1'b1);
    out_chk("R10", 1'b0, 3'd0, 2'd0, 4'h8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule